// File: doc/BRIEF.md
# PWM Channel with Qualified Staged Load

This block is a single pulse-width-modulated output channel. Software-side logic keeps four staging values at the inputs: a prescale divider, a period count, a duty-high count and a polarity flag. The channel never reads the staging inputs directly into its running waveform. A new setting is accepted only through a handshake on the `load_en` input. After `load_en` has been low for a minimum gap, it must rise and stay high for a minimum hold time, given as `HOLD_CYC` clock cycles. If it does, the staged values are captured into a pending register. A second control, `smooth`, then decides when the pending setting takes over.

With `smooth` high, the new setting waits for the current PWM period to end, and lowering `load_en` leaves the running waveform untouched. With `smooth` low, the setting takes over at once. In that mode, lowering `load_en` holds the channel in an idle state with the output forced high. To shut the channel down to a steady level, program all-zero counts with inverted polarity and complete one qualified load.

Top module: `pwm_staged_channel`

## Requirements
- R1: With polarity flag 0, the output repeats every (prescale+1)*(period+1) clock cycles and is high for (prescale+1)*duty cycles of each repetition, when 0 < duty <= period.
- R2: A duty count of 0 with polarity 0 gives a constant low output. A duty count larger than the period count gives a constant high output.
- R3: Polarity flag 1 inverts the waveform: the output is high for (prescale+1)*(period+1-duty) cycles per repetition.
- R4: Staged values are accepted only if `load_en` is sampled high on at least `HOLD_CYC` consecutive clock edges. A shorter high pulse discards them and the previous waveform continues.
- R5: A rise of `load_en` is accepted only if `load_en` was sampled low on at least `HOLD_CYC` consecutive edges before it. After a shorter gap, the staged values are discarded.
- R6: While `smooth` is 0 and `load_en` is 0, the output is held at 1 and the channel counters are cleared.
- R7: While `smooth` is 1 and `load_en` is 0, the running waveform continues unchanged.
- R8: With `smooth` at 1, an accepted setting takes effect only at the end of the running period. The period in progress completes with its old duty.
- R9: During and after reset, the output is 1 until the first accepted setting is applied. Reset clears the active settings.
- R10: Loading prescale 0, period 0, duty 0 and polarity 1 gives a constant high output.
- R11: The staged values are captured when the hold time is met. Later changes to the staging inputs, without a new qualified handshake, do not alter the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stg_prescale | input | 8 | Staged clock divider (divide by value+1) |
| stg_period | input | 24 | Staged period count (period is value+1 ticks) |
| stg_duty | input | 24 | Staged duty-high count, 0 to 0xFFFFFF |
| stg_invert | input | 1 | Staged polarity flag, 1 inverts the output |
| load_en | input | 1 | Output-enable handshake that qualifies a load |
| smooth | input | 1 | 1: switch at period end and keep running when enable drops; 0: switch at once and idle when enable drops |
| pwm_out | output | 1 | PWM waveform |

## Verification
The hardest situation to reach is a qualified load that lands in the middle of a long period while `smooth` is 1. To show that the old duty survives until the boundary, the stimulus first runs a 200-cycle period with a 100-cycle high phase. It then waits for a rising edge of the output and starts the enable handshake at that moment, so qualification falls well inside the high phase. The hold and gap rules are reached by sizing `load_en` pulses to exactly `HOLD_CYC` and `HOLD_CYC-1` sampled edges, with the staged values held steady throughout.

// File: rtl/pwm_stage_pkg.sv
// Package: shared widths and the channel setting record.
// Assumes one prescale width and one counter width for every channel.
package pwm_stage_pkg;
    localparam int PRE_W = 8;
    localparam int CNT_W = 24;

    typedef struct packed {
        logic [PRE_W-1:0] prescale;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] duty;
        logic             invert;
    } pwm_cfg_t;
endpackage

// File: rtl/pwm_hold_qual.sv
// Enable qualifier: emits a one-cycle pulse once load_en has been high for
// HOLD_CYC sampled edges, provided it was low for HOLD_CYC edges beforehand.
// Assumes HOLD_CYC >= 2.
module pwm_hold_qual #(
    parameter int HOLD_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic qual
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HOLD_MAX  = HW'(HOLD_CYC);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

    logic [HW-1:0] hi_cnt;
    logic [HW-1:0] lo_cnt;
    logic          armed;

    // Count high and low run lengths; arm on a rise that followed a full gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= HOLD_MAX;
            armed  <= 1'b0;
            qual   <= 1'b0;
        end else if (en) begin
            lo_cnt <= '0;
            if (hi_cnt != HOLD_MAX) hi_cnt <= hi_cnt + 1'b1;
            if (hi_cnt == '0) armed <= (lo_cnt == HOLD_MAX);
            qual <= armed && (hi_cnt == HOLD_LAST);
        end else begin
            hi_cnt <= '0;
            armed  <= 1'b0;
            qual   <= 1'b0;
            if (lo_cnt != HOLD_MAX) lo_cnt <= lo_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_load_stage.sv
// Pending register: captures the staged setting on a qualify pulse and holds
// it until the wave generator takes it. Assumes staging is steady at qualify.
module pwm_load_stage
    import pwm_stage_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     qual,
    input  pwm_cfg_t stg_cfg,
    input  logic     take,
    output logic     pend_valid,
    output pwm_cfg_t pend_cfg
);
    // Capture on qualify, release when the generator consumes the setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_cfg   <= '0;
        end else if (qual) begin
            pend_valid <= 1'b1;
            pend_cfg   <= stg_cfg;
        end else if (take) begin
            pend_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_wave_gen.sv
// Wave generator: prescaler, period counter and active setting. Applies the
// pending setting at once (smooth=0 or not running) or at a period wrap
// (smooth=1). Idles with output high when smooth=0 and enable is low.
module pwm_wave_gen
    import pwm_stage_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     smooth,
    input  logic     pend_valid,
    input  pwm_cfg_t pend_cfg,
    output logic     take,
    output logic     running,
    output logic     wrap,
    output pwm_cfg_t act_cfg,
    output logic     pwm_out
);
    logic [PRE_W-1:0] pre_cnt;
    logic [CNT_W-1:0] per_cnt;
    logic             idle;
    logic             tick;

    assign idle = !smooth && !en;
    assign tick = (pre_cnt == act_cfg.prescale);
    assign wrap = running && tick && (per_cnt == act_cfg.period);
    assign take = pend_valid && !idle && (!smooth || !running || wrap);

    // Advance counters, enter idle, or switch to the pending setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cfg <= '0;
            running <= 1'b0;
            pre_cnt <= '0;
            per_cnt <= '0;
        end else if (idle) begin
            running <= 1'b0;
            pre_cnt <= '0;
            per_cnt <= '0;
        end else if (take) begin
            act_cfg <= pend_cfg;
            running <= 1'b1;
            pre_cnt <= '0;
            per_cnt <= '0;
        end else if (running) begin
            if (tick) begin
                pre_cnt <= '0;
                per_cnt <= (per_cnt == act_cfg.period) ? '0 : per_cnt + 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    // Raw level is high below the duty count; polarity flips it; idle is high.
    assign pwm_out = running ? ((per_cnt < act_cfg.duty) ^ act_cfg.invert) : 1'b1;
endmodule

// File: rtl/pwm_staged_channel.sv
// Top: one PWM channel whose settings pass staging -> pending -> active under
// the enable hold-time handshake. Assumes HOLD_CYC >= 2.
module pwm_staged_channel
    import pwm_stage_pkg::*;
#(
    parameter int HOLD_CYC = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] stg_prescale,
    input  logic [CNT_W-1:0] stg_period,
    input  logic [CNT_W-1:0] stg_duty,
    input  logic             stg_invert,
    input  logic             load_en,
    input  logic             smooth,
    output logic             pwm_out
);
    pwm_cfg_t stg_cfg;
    pwm_cfg_t pend_cfg;
    pwm_cfg_t act_cfg;
    logic     qual;
    logic     pend_valid;
    logic     take;
    logic     running;
    logic     wrap;
    logic     act_duty_zero;

    assign stg_cfg = '{prescale: stg_prescale, period: stg_period,
                       duty: stg_duty, invert: stg_invert};
    assign act_duty_zero = (act_cfg.duty == '0);

    pwm_hold_qual #(.HOLD_CYC(HOLD_CYC)) u_qual (
        .clk(clk), .rst_n(rst_n), .en(load_en), .qual(qual)
    );

    pwm_load_stage u_stage (
        .clk(clk), .rst_n(rst_n), .qual(qual), .stg_cfg(stg_cfg),
        .take(take), .pend_valid(pend_valid), .pend_cfg(pend_cfg)
    );

    pwm_wave_gen u_wave (
        .clk(clk), .rst_n(rst_n), .en(load_en), .smooth(smooth),
        .pend_valid(pend_valid), .pend_cfg(pend_cfg), .take(take),
        .running(running), .wrap(wrap), .act_cfg(act_cfg), .pwm_out(pwm_out)
    );
endmodule

// File: rtl/pwm_staged_channel_chk.sv
// Checker: temporal properties of the channel, bound into the top module.
module pwm_staged_channel_chk (
    input logic clk,
    input logic rst_n,
    input logic load_en,
    input logic smooth,
    input logic pwm_out,
    input logic qual,
    input logic take,
    input logic running,
    input logic wrap,
    input logic duty_zero,
    input logic inv
);
    // R4: a qualify pulse is preceded by enable high on the last two edges
    a_r4_hold_met: assert property (@(posedge clk) disable iff (!rst_n)
        qual |-> ($past(load_en) && $past(load_en, 2)));

    // R6: non-smooth with enable low forces the output high next cycle
    a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!smooth && !load_en) |=> pwm_out);

    // R8: in smooth mode a running channel switches only at a wrap
    a_r8_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (take && smooth && running) |-> wrap);

    // R9: reset leaves the output at its default high level
    a_r9_reset_high: assert property (@(posedge clk)
        !rst_n |=> pwm_out);

    // R2: a running zero-duty, non-inverted setting drives a low output
    a_r2_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (running && duty_zero && !inv) |-> !pwm_out);
endmodule

bind pwm_staged_channel pwm_staged_channel_chk u_chk (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .smooth(smooth),
    .pwm_out(pwm_out), .qual(qual), .take(take), .running(running),
    .wrap(wrap), .duty_zero(act_duty_zero), .inv(act_cfg.invert)
);

// File: tb/pwm_staged_channel_tb.sv
module pwm_staged_channel_tb;
    localparam int HOLD = 40;

    typedef struct packed {
        logic [7:0]  pre;
        logic [23:0] per;
        logic [23:0] duty;
        logic        inv;
        int          exp_per;
        int          exp_hi;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{8'd0, 24'd9, 24'd3, 1'b0, 10, 3},
        '{8'd1, 24'd4, 24'd2, 1'b0, 10, 4},
        '{8'd3, 24'd2, 24'd1, 1'b0, 12, 4},
        '{8'd0, 24'd7, 24'd5, 1'b1, 8, 3},
        '{8'd2, 24'd5, 24'd5, 1'b1, 18, 3},
        '{8'd1, 24'd9, 24'd1, 1'b0, 20, 2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  stg_prescale = '0;
    logic [23:0] stg_period = '0;
    logic [23:0] stg_duty = '0;
    logic        stg_invert = 1'b0;
    logic        load_en = 1'b0;
    logic        smooth = 1'b1;
    logic        pwm_out;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    pwm_staged_channel #(.HOLD_CYC(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .stg_prescale(stg_prescale),
        .stg_period(stg_period), .stg_duty(stg_duty), .stg_invert(stg_invert),
        .load_en(load_en), .smooth(smooth), .pwm_out(pwm_out)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stage(input logic [7:0] p, input logic [23:0] per,
                         input logic [23:0] d, input logic inv);
        stg_prescale = p; stg_period = per; stg_duty = d; stg_invert = inv;
    endtask

    // full handshake: long gap, long hold, then settle
    task automatic do_load(input logic [7:0] p, input logic [23:0] per,
                           input logic [23:0] d, input logic inv);
        stage(p, per, d, inv);
        load_en = 1'b0;
        wait_cyc(HOLD + 3);
        load_en = 1'b1;
        wait_cyc(HOLD + 3);
        wait_cyc(300);
    endtask

    task automatic measure(output int per, output int hi);
        int prev;
        int cur;
        int n;
        bit found;
        per = -1; hi = -1; found = 1'b0;
        prev = int'(pwm_out);
        cur = prev;
        for (n = 0; n < 2000 && !found; n++) begin
            @(negedge clk);
            cur = int'(pwm_out);
            if (prev == 0 && cur == 1) found = 1'b1;
            prev = cur;
        end
        if (!found) return;
        per = 0; hi = 0; found = 1'b0;
        for (int m = 0; m < 2000 && !found; m++) begin
            hi += prev;
            per++;
            @(negedge clk);
            cur = int'(pwm_out);
            if (prev == 0 && cur == 1) found = 1'b1;
            prev = cur;
        end
        if (!found) begin per = -1; hi = -1; end
    endtask

    task automatic check_wave(input string req, input int ep, input int eh);
        int p;
        int h;
        measure(p, h);
        check_eq({req, " period"}, p, ep);
        check_eq({req, " high"}, h, eh);
    endtask

    task automatic check_const(input string req, input logic lvl, input int n);
        int bad;
        bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out !== lvl) bad++;
        end
        check_eq({req, " mismatching samples"}, bad, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        wait (cycles >= 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        int hc;
        int lc;
        bit stop;
        // R9: reset state and output after reset
        wait_cyc(2);
        check_eq("R9 output in reset", int'(pwm_out), 1);
        wait_cyc(3);
        rst_n = 1'b1;
        check_const("R9 output after reset", 1'b1, 60);

        // R1 / R3: table of settings, smooth mode
        smooth = 1'b1;
        foreach (TBL[i]) begin
            do_load(TBL[i].pre, TBL[i].per, TBL[i].duty, TBL[i].inv);
            check_wave(TBL[i].inv ? "R3" : "R1", TBL[i].exp_per, TBL[i].exp_hi);
        end

        // R7: enable low in smooth mode keeps the last waveform (20/2)
        load_en = 1'b0;
        wait_cyc(300);
        check_wave("R7", 20, 2);

        // R4: hold one edge short -> discarded
        stage(8'd0, 24'd9, 24'd3, 1'b0);
        wait_cyc(HOLD + 3);
        load_en = 1'b1;
        wait_cyc(HOLD - 1);
        load_en = 1'b0;
        wait_cyc(300);
        check_wave("R4 short hold", 20, 2);

        // R4: hold exactly HOLD edges -> accepted
        wait_cyc(HOLD + 3);
        load_en = 1'b1;
        wait_cyc(HOLD);
        load_en = 1'b0;
        wait_cyc(300);
        check_wave("R4 exact hold", 10, 3);

        // R5: gap one edge short -> discarded
        load_en = 1'b1;
        wait_cyc(HOLD + 3);
        stage(8'd0, 24'd7, 24'd2, 1'b0);
        load_en = 1'b0;
        wait_cyc(HOLD - 1);
        load_en = 1'b1;
        wait_cyc(HOLD + 10);
        wait_cyc(300);
        check_wave("R5 short gap", 10, 3);

        // R5: gap exactly HOLD edges -> accepted
        load_en = 1'b0;
        wait_cyc(HOLD);
        load_en = 1'b1;
        wait_cyc(HOLD + 10);
        wait_cyc(300);
        check_wave("R5 exact gap", 8, 2);

        // R11: staging changes without a handshake are ignored
        stage(8'd1, 24'd4, 24'd4, 1'b0);
        wait_cyc(300);
        check_wave("R11", 8, 2);

        // R2: zero duty -> constant low; duty above period -> constant high
        do_load(8'd0, 24'd4, 24'd0, 1'b0);
        check_const("R2 zero duty", 1'b0, 60);
        do_load(8'd0, 24'd4, 24'd7, 1'b0);
        check_const("R2 duty above period", 1'b1, 60);

        // R8: smooth switch waits for the end of a 200-cycle period
        do_load(8'd0, 24'd199, 24'd100, 1'b0);
        load_en = 1'b0;
        wait_cyc(HOLD + 3);
        stage(8'd0, 24'd3, 24'd1, 1'b0);
        stop = 1'b0;
        for (int n = 0; n < 400 && !stop; n++) begin
            @(negedge clk);
            if (pwm_out) stop = 1'b1;
        end
        stop = 1'b0;
        for (int n = 0; n < 400 && !stop; n++) begin
            @(negedge clk);
            if (!pwm_out) stop = 1'b1;
        end
        stop = 1'b0;
        for (int n = 0; n < 400 && !stop; n++) begin
            @(negedge clk);
            if (pwm_out) stop = 1'b1;
        end
        load_en = 1'b1;
        hc = 1;
        stop = 1'b0;
        for (int n = 0; n < 400 && !stop; n++) begin
            @(negedge clk);
            if (pwm_out) hc++; else stop = 1'b1;
        end
        check_eq("R8 old high phase kept", hc, 100);
        lc = 1;
        stop = 1'b0;
        for (int n = 0; n < 400 && !stop; n++) begin
            @(negedge clk);
            if (!pwm_out) lc++; else stop = 1'b1;
        end
        check_eq("R8 old low phase kept", lc, 100);
        check_wave("R8 new setting", 4, 1);

        // R6: non-smooth, enable low -> idle high
        smooth = 1'b0;
        load_en = 1'b0;
        wait_cyc(2);
        check_const("R6 idle high", 1'b1, 100);

        // R6: non-smooth reload restarts the channel
        stage(8'd1, 24'd4, 24'd2, 1'b0);
        wait_cyc(HOLD + 3);
        load_en = 1'b1;
        wait_cyc(HOLD + 3);
        wait_cyc(50);
        check_wave("R6 restart", 10, 4);

        // R10: shutdown sequence -> constant high
        load_en = 1'b0;
        wait_cyc(HOLD + 3);
        stage(8'd0, 24'd0, 24'd0, 1'b1);
        load_en = 1'b1;
        wait_cyc(HOLD + 5);
        check_const("R10 quiescent", 1'b1, 100);

        done = 1'b1;
        finish_run();
    end
endmodule